// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher (ten rounds), using an 8-bit datapath so that it stays small. A single pulse on `start` captures the key and the plaintext. The core then works through the cipher one byte per clock and raises `done` for one cycle when `ciphertext` holds the result. The ciphertext stays on the port until the next accepted start.

Every substitution goes through one shared byte substitution unit. This covers the sixteen state bytes of each round and the four key bytes that each round-key step needs. The unit computes the field inverse by reducing the byte to its norm in the 16-element subfield and inverting there. It then applies the affine output map, so no 256-entry table is stored. Row rotation costs no logic: the controller reads state bytes in rotated order. Column mixing builds up each output column over four consecutive cycles. The next round key is derived in place, one byte per cycle, from the current one.

The controller has four states. IDLE waits for `start`. WHITEN XORs the key into the state, one byte per cycle, for 16 cycles. KEYGEN updates the round key for 16 cycles. ROUND substitutes, mixes and adds the key for 16 cycles. The transitions are: IDLE to WHITEN on `start`; WHITEN to KEYGEN after its 16th byte; KEYGEN to ROUND after its 16th byte; ROUND to KEYGEN after its 16th byte when rounds remain; ROUND to IDLE, raising `done`, after the 16th byte of the last round. An encryption therefore takes 16 + 32 x 10 = 336 cycles.

Top module: `aesb_core`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a. With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734 it is 3925841d02dc09fbdc118597196a0b32. Byte 0 is bits 127:120 of each 128-bit port, and bytes fill the state column by column.
- R2: For arbitrary key and plaintext pairs the ciphertext equals the AES-128 encryption of the plaintext under the key.
- R3: `done` first reads high exactly 336 rising edges after the edge that sampled `start` high.
- R4: `done` is high for exactly one cycle per encryption, and only once the core has returned to IDLE.
- R5: After `done`, `ciphertext` keeps its value while `start` stays low, whatever `key` and `plaintext` do.
- R6: A `start` pulse while an encryption is running is ignored. The running result and its 336-cycle latency are unchanged.
- R7: After reset `done` is 0 and `ciphertext` is all zeros.
- R8: The substitution matches the standard AES S-box for every one of the 256 byte values. This is seen through the ciphertexts of plaintexts whose first-round inputs sweep all 256 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an encryption; sampled only in IDLE |
| key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| plaintext | input | 128 | Input block, byte 0 in bits 127:120 |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext | output | 128 | Encrypted block, held until the next start |

## Verification
The bench builds the core with the default `ROUNDS = 10`. This makes it the standard cipher, so the two published known answers and a reference model inside the bench apply directly, and the 336-cycle latency can be measured edge by edge. A set of sixteen plaintexts under an all-zero key drives every byte value into the first-round substitution. A second start sent in the middle of a run, with different operands on the inputs, tests that a busy core ignores it.

// File: rtl/aesb_pkg.sv
package aesb_pkg;

    localparam int BLOCK_BYTES = 16;
    localparam int BYTE_W      = 8;
    localparam int BLOCK_W     = BLOCK_BYTES * BYTE_W;
    localparam int COL_W       = 4 * BYTE_W;
    localparam int IDX_W       = $clog2(BLOCK_BYTES);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WHITEN = 2'd1,
        S_KEYGEN = 2'd2,
        S_ROUND  = 2'd3
    } phase_t;

    // multiply by x modulo the AES field polynomial
    function automatic logic [7:0] xtime(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/aesb_sbox.sv
// Byte substitution: inverse through the norm into GF(16), then affine map.
module aesb_sbox
    import aesb_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] p2, p4, p8, p16;
    logic [7:0] norm, n2, n4, n8, n_inv, inv;

    always_comb begin
        p2    = gmul(din, din);
        p4    = gmul(p2, p2);
        p8    = gmul(p4, p4);
        p16   = gmul(p8, p8);
        // a^17 lies in the 16-element subfield
        norm  = gmul(p16, din);
        n2    = gmul(norm, norm);
        n4    = gmul(n2, n2);
        n8    = gmul(n4, n4);
        // subfield inverse: n^14
        n_inv = gmul(gmul(n8, n4), n2);
        inv   = gmul(n_inv, p16);
        dout  = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/aesb_keysched.sv
// In-place round-key update, one byte per step.
module aesb_keysched
    import aesb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLOCK_W-1:0] key_in,
    input  logic               step,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         sub_in,
    output logic [7:0]         sub_req,
    output logic [BLOCK_W-1:0] round_key
);
    logic [BLOCK_W-1:0] key_r;
    logic [7:0]         rcon_r;
    logic [7:0]         old_b, prev_b, upd_b;
    logic [3:0]         req_idx;

    // the first word takes bytes 13,14,15,12 of the last word through the S-box
    assign req_idx   = {2'b11, idx[1:0] + 2'd1};
    assign sub_req   = key_r[{4'd15 - req_idx, 3'b000} +: 8];
    assign old_b     = key_r[{4'd15 - idx, 3'b000} +: 8];
    assign prev_b    = key_r[{4'd15 - (idx - 4'd4), 3'b000} +: 8];
    assign round_key = key_r;

    always_comb begin
        if (idx[3:2] == 2'b00)
            upd_b = old_b ^ sub_in ^ ((idx == 4'd0) ? rcon_r : 8'h00);
        else
            upd_b = old_b ^ prev_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_r  <= '0;
            rcon_r <= 8'h01;
        end else if (load) begin
            key_r  <= key_in;
            rcon_r <= 8'h01;
        end else if (step) begin
            key_r[{4'd15 - idx, 3'b000} +: 8] <= upd_b;
            if (idx == 4'hF) rcon_r <= xtime(rcon_r);
        end
    end
endmodule

// File: rtl/aesb_mixacc.sv
// Serial column mixer: one substituted byte per cycle, column complete at row 3.
module aesb_mixacc
    import aesb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       row,
    input  logic             skip_mix,
    input  logic [7:0]       sub_in,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] acc_r;
    logic [COL_W-1:0] contrib;
    logic [7:0]       dbl;

    assign dbl = xtime(sub_in);

    for (genvar k = 0; k < 4; k++) begin : g_out_row
        always_comb begin
            if (skip_mix)
                contrib[COL_W-1-8*k -: 8] = (row == 2'(k)) ? sub_in : 8'h00;
            else if (row == 2'(k))
                contrib[COL_W-1-8*k -: 8] = dbl;
            else if (row == 2'((k + 1) % 4))
                contrib[COL_W-1-8*k -: 8] = dbl ^ sub_in;
            else
                contrib[COL_W-1-8*k -: 8] = sub_in;
        end
    end

    assign col_out = ((row == 2'd0) ? '0 : acc_r) ^ contrib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc_r <= '0;
        else if (en) acc_r <= col_out;
    end
endmodule

// File: rtl/aesb_core.sv
module aesb_core
    import aesb_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLOCK_W-1:0] key,
    input  logic [BLOCK_W-1:0] plaintext,
    output logic               done,
    output logic [BLOCK_W-1:0] ciphertext
);
    localparam int RW      = $clog2(ROUNDS);
    localparam int LATENCY = BLOCK_BYTES + 2 * BLOCK_BYTES * ROUNDS;
    localparam int LW      = $clog2(LATENCY + 1);

    phase_t             phase;
    logic [IDX_W-1:0]   idx;
    logic [RW-1:0]      rnd;
    logic [BLOCK_W-1:0] state_r;
    logic [BLOCK_W-COL_W-1:0] nxt_r;
    logic               done_r;

    logic [1:0]         col, row, src_col;
    logic [3:0]         rd_idx;
    logic [7:0]         shifted_b, plain_b, key_b, sbox_in, sbox_out, key_req;
    logic [BLOCK_W-1:0] rkey;
    logic [COL_W-1:0]   mix_col, key_col, new_col;
    logic               last_byte, last_round;

    assign col        = idx[3:2];
    assign row        = idx[1:0];
    assign src_col    = col + row;          // row rotation by read order
    assign rd_idx     = {src_col, row};
    assign shifted_b  = state_r[{4'd15 - rd_idx, 3'b000} +: 8];
    assign plain_b    = state_r[{4'd15 - idx, 3'b000} +: 8];
    assign key_b      = rkey[{4'd15 - idx, 3'b000} +: 8];
    assign last_byte  = (idx == 4'hF);
    assign last_round = (rnd == RW'(ROUNDS - 1));
    assign sbox_in    = (phase == S_KEYGEN) ? key_req : shifted_b;
    assign key_col    = rkey[{2'd3 - col, 5'd0} +: COL_W];
    assign new_col    = mix_col ^ key_col;

    aesb_sbox u_sbox (.din(sbox_in), .dout(sbox_out));

    aesb_keysched u_keysched (
        .clk(clk), .rst_n(rst_n),
        .load(phase == S_IDLE && start), .key_in(key),
        .step(phase == S_KEYGEN), .idx(idx),
        .sub_in(sbox_out), .sub_req(key_req), .round_key(rkey)
    );

    aesb_mixacc u_mixacc (
        .clk(clk), .rst_n(rst_n), .en(phase == S_ROUND), .row(row),
        .skip_mix(last_round), .sub_in(sbox_out), .col_out(mix_col)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= S_IDLE;
            idx   <= '0;
            rnd   <= '0;
        end else begin
            unique case (phase)
                S_IDLE: if (start) begin
                    phase <= S_WHITEN;
                    idx   <= '0;
                    rnd   <= '0;
                end
                S_WHITEN: begin
                    idx <= idx + 1'b1;
                    if (last_byte) phase <= S_KEYGEN;
                end
                S_KEYGEN: begin
                    idx <= idx + 1'b1;
                    if (last_byte) phase <= S_ROUND;
                end
                S_ROUND: begin
                    idx <= idx + 1'b1;
                    if (last_byte) begin
                        if (last_round) phase <= S_IDLE;
                        else begin
                            phase <= S_KEYGEN;
                            rnd   <= rnd + 1'b1;
                        end
                    end
                end
                default: phase <= S_IDLE;
            endcase
        end
    end

    // data and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= '0;
            nxt_r   <= '0;
            done_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (phase)
                S_IDLE:   if (start) state_r <= plaintext;
                S_WHITEN: state_r[{4'd15 - idx, 3'b000} +: 8] <= plain_b ^ key_b;
                S_ROUND: if (row == 2'd3) begin
                    if (col == 2'd3) begin
                        state_r <= {nxt_r, new_col};
                        if (last_round) done_r <= 1'b1;
                    end else begin
                        nxt_r[{2'd2 - col, 5'd0} +: COL_W] <= new_col;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done       = done_r;
    assign ciphertext = state_r;

    // checker state: edges since the accepted start
    logic [LW-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               lat_cnt <= '0;
        else if (phase == S_IDLE) lat_cnt <= '0;
        else                      lat_cnt <= lat_cnt + 1'b1;
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LW'(LATENCY)));
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == S_IDLE));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_IDLE && !start) |=> $stable(ciphertext));
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != S_IDLE && start) |=> (phase != S_IDLE || done));
endmodule

// File: tb/test_aesb_core.sv
module test_aesb_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] plaintext = '0;
    logic         done;
    logic [127:0] ciphertext;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] sb_tab [256];

    always #10 clk = ~clk;

    aesb_core i_aesb_core (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .plaintext(plaintext), .done(done), .ciphertext(ciphertext)
    );

    function automatic logic [7:0] t_xt(input logic [7:0] v);
        return v[7] ? ({v[6:0], 1'b0} ^ 8'h1b) : {v[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] t_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] m = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= m;
            m = t_xt(m);
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] k_in, input logic [127:0] p_in);
        logic [7:0] s [16];
        logic [7:0] u [16];
        logic [7:0] k [16];
        logic [7:0] t [4];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            k[i] = k_in[127-8*i -: 8];
            s[i] = p_in[127-8*i -: 8] ^ k[i];
        end
        for (int r = 1; r <= 10; r++) begin
            t[0] = sb_tab[k[13]] ^ rc; t[1] = sb_tab[k[14]];
            t[2] = sb_tab[k[15]];      t[3] = sb_tab[k[12]];
            for (int i = 0; i < 4; i++)  k[i] ^= t[i];
            for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
            rc = t_xt(rc);
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++)
                    u[4*c+w] = sb_tab[s[4*((c+w)%4)+w]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) begin
                    if (r < 10)
                        s[4*c+w] = t_mul(u[4*c+w], 8'h02) ^ t_mul(u[4*c+(w+1)%4], 8'h03)
                                 ^ u[4*c+(w+2)%4] ^ u[4*c+(w+3)%4];
                    else
                        s[4*c+w] = u[4*c+w];
                end
            for (int i = 0; i < 16; i++) s[i] ^= k[i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    task automatic check_vec(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_num(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one encryption; returns ciphertext and edges from start to done
    task automatic run_enc(input logic [127:0] p, input logic [127:0] k,
                           output logic [127:0] ct, output int cyc);
        @(negedge clk);
        plaintext = p; key = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        ct = ciphertext;
        @(negedge clk);
        check_num("R4 done low one cycle after pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        check_num("R7 done after reset", int'(done), 0);
        check_vec("R7 ciphertext after reset", ciphertext, '0);
    endtask

    task automatic t_known();
        logic [127:0] ct;
        int cyc;
        run_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, ct, cyc);
        check_vec("R1 known answer A", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        check_num("R3 latency A", cyc, 336);
        run_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, ct, cyc);
        check_vec("R1 known answer B", ct, 128'h3925841d02dc09fbdc118597196a0b32);
        check_num("R3 latency B", cyc, 336);
    endtask

    task automatic t_random();
        logic [127:0] ct, p, k;
        int cyc;
        for (int n = 0; n < 6; n++) begin
            p = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            run_enc(p, k, ct, cyc);
            check_vec("R2 random pair", ct, ref_enc(k, p));
            check_num("R3 latency random", cyc, 336);
        end
    endtask

    task automatic t_sbox_sweep();
        logic [127:0] ct, p;
        int cyc;
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 16; i++) p[127-8*i -: 8] = 8'(16*m + i);
            run_enc(p, '0, ct, cyc);
            check_vec("R8 substitution sweep", ct, ref_enc('0, p));
        end
    endtask

    task automatic t_busy();
        logic [127:0] pa = 128'hdeadbeef0123456789abcdeffedcba98;
        logic [127:0] ka = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        int cyc = 0;
        @(negedge clk);
        plaintext = pa; key = ka; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 2000) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (cyc == 40) begin
                plaintext = ~pa; key = ~ka; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check_vec("R6 result ignores busy start", ciphertext, ref_enc(ka, pa));
        check_num("R6 latency with busy start", cyc, 336);
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [127:0] ct;
        int cyc;
        run_enc(128'h0123456789abcdef0123456789abcdef, 128'hffeeddccbbaa99887766554433221100, ct, cyc);
        plaintext = '1; key = 128'h5a5a;
        repeat (25) @(negedge clk);
        check_vec("R5 ciphertext held while idle", ciphertext, ct);
        check_num("R5 no done while idle", int'(done), 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (t_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            sb_tab[a] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                      ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        t_random();
        t_sbox_sweep();
        t_busy();
        t_hold();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule